// File: doc/BRIEF.md
# Dual-ADC Acquisition Sequencer

This block runs two serial-output analog-to-digital converters from one shared sampling schedule. For every sample it raises a conversion-start strobe of programmable width on both converters at once. It waits a programmable settling time after the strobe ends. It then acts as a serial master, clocking one 16-bit result out of each converter, and writes the two results into a sample memory that is split into one segment per channel. Sampling repeats at a programmable period. The readout always completes before the next strobe is issued.

Samples are grouped into bursts, and the acquisition mode decides when a burst begins. The mode can repeat bursts on a fixed interval, run one burst per start request, sample without a count limit while start is held, or wait for rising edges of an external trigger. A burst that would begin while the host has not yet emptied the previous data is dropped without any report. Configuration inputs are expected to stay stable while `busy` is high.

Top module: `dual_adc_seq`

## Requirements
- R1: Both conversion-start outputs `adc_cnv[0]` and `adc_cnv[1]` rise on the same clock edge and fall on the same clock edge.
- R2: Each conversion-start pulse is high for exactly `cfg_width` clocks (minimum 1). Within a burst, consecutive rising edges are max(`cfg_period`, `cfg_width`+`cfg_wait`+36) clocks apart.
- R3: No conversion-start pulse is high while either chip select `adc_cs_n` is low. The readout of one conversion ends before the next pulse begins.
- R4: The serial clock runs at half the system rate, high for one clock and low for the next. It gives 16 high pulses per conversion, and its first rise comes `cfg_wait`+1 clocks after the conversion pulse falls. It is low whenever both chip selects are high. MISO is captured MSB first at the clock edge that ends each serial-clock high phase.
- R5: Each sample makes two consecutive one-clock memory writes. Channel 0 goes to word address n and channel 1 to word address `cfg_split`+n, where n counts samples from 0 within the burst.
- R6: A burst ends after `cfg_count` samples, or when n reaches the segment capacity min(`cfg_split`, 8192-`cfg_split`), whichever comes first. `samples` reports n.
- R7: `cfg_mode` value 0 (interval): a rising edge of `start` launches a burst, and further launch attempts follow every `cfg_interval` clocks while `start` stays high.
- R8: `cfg_mode` value 1 (single): each rising edge of `start` launches exactly one burst.
- R9: `cfg_mode` value 2 (continuous): a rising edge of `start` launches a burst that ignores `cfg_count`. It stops at the end of the first sample completed with `start` low, or when the segment is full.
- R10: `cfg_mode` value 3 (trigger): while `start` is high, a rising edge of `trig` passes through two synchronizing flops and launches a burst. `busy` rises 3 clocks after the trigger input rises, and trigger edges during an active burst are ignored.
- R11: A launch attempt made while `drained` is low, or (in interval mode) while a burst is still running, is dropped. No burst starts and `done` keeps its value.
- R12: After reset `busy`, `done`, `adc_cnv`, `adc_sclk` and `mem_we` are 0 and `adc_cs_n` is 2'b11. `busy` rises one clock after a launch and falls in the clock where `done` is set. `done` is cleared by the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Acquisition mode: 0 interval, 1 single, 2 continuous, 3 trigger |
| cfg_period | input | TW | Sampling period in clocks |
| cfg_width | input | TW | Conversion-start pulse width in clocks |
| cfg_wait | input | TW | Clocks from pulse end to the readout start |
| cfg_interval | input | IW | Clocks between burst launch attempts in interval mode |
| cfg_count | input | AW+1 | Samples per burst |
| cfg_split | input | AW | First word of the channel 1 segment |
| start | input | 1 | Acquisition request, level with edge meaning per mode |
| trig | input | 1 | Asynchronous external burst trigger |
| drained | input | 1 | High when the host has emptied the sample memory |
| adc_cnv | output | 2 | Conversion-start strobes, one per converter |
| adc_cs_n | output | 2 | Active-low chip selects, one per converter |
| adc_sclk | output | 1 | Shared serial clock |
| adc_miso | input | 2 | Serial data from each converter |
| mem_we | output | 1 | Sample memory write enable |
| mem_addr | output | AW | Sample memory word address |
| mem_wdata | output | 16 | Sample word |
| busy | output | 1 | A burst is running |
| done | output | 1 | The last burst has finished |
| samples | output | AW+1 | Samples taken in the current or last burst |

## Verification
A launch shows on `busy` one clock after the edge that sees the start edge, and three clocks after the trigger input rises. The conversion pulse then spaces its rising edges by max(period, width+wait+36) clocks. The first serial-clock rise comes wait+1 clocks after the pulse falls, and the channel 0 and channel 1 writes follow on consecutive clocks after the sixteenth capture. The bench drives inputs and reads outputs on the falling clock edge and measures every interval with a cycle counter that advances on the rising edge, so each expected distance is compared in whole clocks. The converter model changes MISO only after a serial-clock fall, so each bit is stable over the capture edge.

// File: rtl/dseq_pkg.sv
// Shared types for the dual-converter acquisition sequencer.
// Assumes two converters that share one sampling schedule.
package dseq_pkg;
    localparam int NCH = 2;

    typedef enum logic [1:0] {
        MODE_ITER   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_CONT   = 2'd2,
        MODE_TRIG   = 2'd3
    } acq_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_CNV, PH_WAIT, PH_SHIFT, PH_LAST, PH_WR0, PH_WR1, PH_GAP
    } phase_e;
endpackage

// File: rtl/conv_engine.sv
// Per-sample timing engine: conversion pulse, settle wait, 2*DATA_W
// half-rate serial clocks, one capture slot, two write slots, then a gap
// until the period expires. Assumes the configuration is stable while run is high.
module conv_engine
    import dseq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TW     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] cfg_period,
    input  logic [TW-1:0] cfg_width,
    input  logic [TW-1:0] cfg_wait,
    output phase_e        phase,
    output logic          cnv_nxt,
    output logic          cs_nxt,
    output logic          sclk_nxt
);
    localparam logic [TW-1:0] SHIFT_LAST = TW'(2 * DATA_W - 1);

    logic [TW-1:0] pcnt;
    logic [TW-1:0] tcnt;

    // Phase sequencing with a period counter and a phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            pcnt  <= '0;
            tcnt  <= '0;
        end else begin
            if (pcnt != '1) pcnt <= pcnt + 1'b1;
            tcnt <= tcnt + 1'b1;
            case (phase)
                PH_IDLE: if (run) begin
                    phase <= PH_CNV;
                    pcnt  <= '0;
                    tcnt  <= '0;
                end
                PH_CNV: if ((tcnt + 1'b1) >= cfg_width) begin
                    tcnt  <= '0;
                    phase <= (cfg_wait == '0) ? PH_SHIFT : PH_WAIT;
                end
                PH_WAIT: if ((tcnt + 1'b1) >= cfg_wait) begin
                    tcnt  <= '0;
                    phase <= PH_SHIFT;
                end
                PH_SHIFT: if (tcnt == SHIFT_LAST) phase <= PH_LAST;
                PH_LAST:  phase <= PH_WR0;
                PH_WR0:   phase <= PH_WR1;
                PH_WR1:   phase <= PH_GAP;
                PH_GAP: begin
                    if (!run) begin
                        phase <= PH_IDLE;
                    end else if ((pcnt + 1'b1) >= cfg_period) begin
                        phase <= PH_CNV;
                        pcnt  <= '0;
                        tcnt  <= '0;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Pin-level intent for the next clock, registered in the lanes.
    always_comb begin
        cnv_nxt  = (phase == PH_CNV);
        cs_nxt   = (phase == PH_SHIFT);
        sclk_nxt = (phase == PH_SHIFT) && tcnt[0];
    end
endmodule

// File: rtl/adc_lane.sv
// One converter lane: registered conversion strobe and chip select, and a
// shift register that takes MISO MSB first while the registered serial clock
// is high. Every lane registers the same shared intent on the same edge.
module adc_lane #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_nxt,
    input  logic              cs_nxt,
    input  logic              cap,
    input  logic              miso,
    output logic              cnv,
    output logic              cs_n,
    output logic [DATA_W-1:0] data
);
    // Pin registers and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv  <= 1'b0;
            cs_n <= 1'b1;
            data <= '0;
        end else begin
            cnv  <= cnv_nxt;
            cs_n <= !cs_nxt;
            if (cap) data <= {data[DATA_W-2:0], miso};
        end
    end
endmodule

// File: rtl/burst_ctl.sv
// Burst control: decides when a burst launches for each mode, synchronizes
// the trigger, drops launches while data is undrained, and ends a burst on
// the sample count or a full segment. Assumes start is synchronous.
module burst_ctl
    import dseq_pkg::*;
#(
    parameter int AW    = 13,
    parameter int DEPTH = 8192,
    parameter int IW    = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  acq_mode_e     mode,
    input  logic          start,
    input  logic          trig,
    input  logic          drained,
    input  logic [IW-1:0] cfg_interval,
    input  logic [AW:0]   cfg_count,
    input  logic [AW-1:0] cfg_split,
    input  logic          sample_done,
    output logic          run,
    output logic          done,
    output logic [AW:0]   idx
);
    localparam logic [AW:0] DEPTH_V = (AW + 1)'(DEPTH);

    logic          start_q;
    logic [2:0]    tsync;
    logic [IW-1:0] ivl_cnt;
    logic [AW:0]   cap_lim, hi_sz, lo_sz, nxt_idx;
    logic          start_rise, trig_rise, ivl_hit, try_go, launch, end_now;

    // Launch and end conditions.
    always_comb begin
        lo_sz      = {1'b0, cfg_split};
        hi_sz      = DEPTH_V - lo_sz;
        cap_lim    = (lo_sz < hi_sz) ? lo_sz : hi_sz;
        nxt_idx    = idx + 1'b1;
        start_rise = start && !start_q;
        trig_rise  = tsync[1] && !tsync[2];
        ivl_hit    = (mode == MODE_ITER) && start && start_q
                     && ((ivl_cnt + 1'b1) >= cfg_interval);
        try_go     = ((mode != MODE_TRIG) && start_rise) || ivl_hit
                     || ((mode == MODE_TRIG) && start && trig_rise);
        launch     = try_go && drained && !run;
        end_now    = sample_done && run
                     && (((mode != MODE_CONT) && (nxt_idx >= cfg_count))
                         || (nxt_idx >= cap_lim)
                         || ((mode == MODE_CONT) && !start));
    end

    // Edge detectors, trigger synchronizer and interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            tsync   <= '0;
            ivl_cnt <= '0;
        end else begin
            start_q <= start;
            tsync   <= {tsync[1:0], trig};
            if (!start || (mode != MODE_ITER) || start_rise || ivl_hit) ivl_cnt <= '0;
            else ivl_cnt <= ivl_cnt + 1'b1;
        end
    end

    // Burst state and sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            done <= 1'b0;
            idx  <= '0;
        end else if (launch) begin
            run  <= 1'b1;
            done <= 1'b0;
            idx  <= '0;
        end else if (sample_done) begin
            idx <= nxt_idx;
            if (end_now) begin
                run  <= 1'b0;
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dual_adc_seq.sv
// Top of the dual-converter acquisition sequencer. Shares one timing engine
// across NCH converter lanes and writes each sample pair to a memory split
// at cfg_split. Assumes configuration is held stable while busy is high.
module dual_adc_seq
    import dseq_pkg::*;
#(
    parameter int  DATA_W    = 16,
    parameter int  MEM_BYTES = 16384,
    parameter int  TW        = 16,
    parameter int  IW        = 24,
    localparam int DEPTH     = MEM_BYTES / (DATA_W / 8),
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [TW-1:0]     cfg_period,
    input  logic [TW-1:0]     cfg_width,
    input  logic [TW-1:0]     cfg_wait,
    input  logic [IW-1:0]     cfg_interval,
    input  logic [AW:0]       cfg_count,
    input  logic [AW-1:0]     cfg_split,
    input  logic              start,
    input  logic              trig,
    input  logic              drained,
    output logic [NCH-1:0]    adc_cnv,
    output logic [NCH-1:0]    adc_cs_n,
    output logic              adc_sclk,
    input  logic [NCH-1:0]    adc_miso,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [AW:0]       samples
);
    phase_e            phase;
    logic              cnv_nxt, cs_nxt, sclk_nxt;
    logic [DATA_W-1:0] lane_data [NCH];

    conv_engine #(.DATA_W(DATA_W), .TW(TW)) u_engine (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .cfg_period(cfg_period), .cfg_width(cfg_width), .cfg_wait(cfg_wait),
        .phase(phase), .cnv_nxt(cnv_nxt), .cs_nxt(cs_nxt), .sclk_nxt(sclk_nxt)
    );

    burst_ctl #(.AW(AW), .DEPTH(DEPTH), .IW(IW)) u_burst (
        .clk(clk), .rst_n(rst_n), .mode(acq_mode_e'(cfg_mode)),
        .start(start), .trig(trig), .drained(drained),
        .cfg_interval(cfg_interval), .cfg_count(cfg_count), .cfg_split(cfg_split),
        .sample_done(phase == PH_WR1),
        .run(busy), .done(done), .idx(samples)
    );

    // Shared serial clock register, aligned with the lane pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) adc_sclk <= 1'b0;
        else        adc_sclk <= sclk_nxt;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        adc_lane #(.DATA_W(DATA_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .cnv_nxt(cnv_nxt), .cs_nxt(cs_nxt),
            .cap(adc_sclk), .miso(adc_miso[c]),
            .cnv(adc_cnv[c]), .cs_n(adc_cs_n[c]), .data(lane_data[c])
        );
    end

    // Memory write port: channel 0 then channel 1 on consecutive clocks.
    always_comb begin
        mem_we    = (phase == PH_WR0) || (phase == PH_WR1);
        mem_addr  = samples[AW-1:0];
        mem_wdata = lane_data[0];
        if (phase == PH_WR1) begin
            mem_addr  = cfg_split + samples[AW-1:0];
            mem_wdata = lane_data[1];
        end
    end
endmodule

// File: rtl/dseq_checker.sv
// Protocol checker for dual_adc_seq, attached by bind. Observes pins only.
module dseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] adc_cnv,
    input logic [1:0] adc_cs_n,
    input logic       adc_sclk,
    input logic       mem_we,
    input logic       busy,
    input logic       done
);
    assert_cnv_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cnv[0] == adc_cnv[1]);

    assert_cnv_not_in_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cnv[0] |-> (adc_cs_n == 2'b11));

    assert_sclk_half_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sclk |=> !adc_sclk);

    assert_sclk_needs_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sclk |-> (adc_cs_n == 2'b00));

    assert_write_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    assert_done_on_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind dual_adc_seq dseq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .adc_cnv(adc_cnv), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .mem_we(mem_we), .busy(busy), .done(done)
);

// File: tb/test_dual_adc_seq.sv
`timescale 1ns/1ps
module test_dual_adc_seq;
    localparam int AW = 13;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd1;
    logic [15:0] cfg_period = 16'd60, cfg_width = 16'd3, cfg_wait = 16'd2;
    logic [23:0] cfg_interval = 24'd400;
    logic [AW:0] cfg_count = 14'd4;
    logic [AW-1:0] cfg_split = 13'd100;
    logic start = 1'b0, trig = 1'b0, drained = 1'b1;
    logic [1:0] adc_cnv, adc_cs_n, adc_miso;
    logic adc_sclk, mem_we, busy, done;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [AW:0] samples;

    dual_adc_seq i_dual_adc_seq (.*);

    always #4 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Converter model and pin monitor
    logic [1:0] miso_drv = 2'b11;
    assign adc_miso = miso_drv;
    logic pcnv = 0, psclk = 0, pbusy = 0, wsel = 0, sclk_seen = 0, have_rise = 0;
    int rise_t, fall_t, bitidx = 0, npulse = 0, widx = 0, n_bursts = 0;
    logic [15:0] cur0 = 0, cur1 = 0;
    logic [15:0] q0[$], q1[$];
    int brise[$];

    function automatic int exp_spacing();
        int m = int'(cfg_width) + int'(cfg_wait) + 36;
        return (int'(cfg_period) > m) ? int'(cfg_period) : m;
    endfunction

    always @(negedge clk) if (rst_n) begin
        if (adc_cnv != {2{pcnv}}) chk(adc_cnv[0] == adc_cnv[1], "R1 strobes aligned", adc_cnv[1], adc_cnv[0]);
        if (busy && !pbusy) begin n_bursts++; brise.push_back(cyc); widx = 0; wsel = 0; end
        if (adc_cnv[0] && !pcnv) begin
            if (have_rise) chk(cyc - rise_t == exp_spacing(), "R2 strobe spacing", cyc - rise_t, exp_spacing());
            chk(adc_cs_n == 2'b11, "R3 no read during strobe", adc_cs_n, 3);
            have_rise = 1; rise_t = cyc; npulse = 0;
            cur0 = 16'($urandom); cur1 = 16'($urandom);
            q0.push_back(cur0); q1.push_back(cur1);
        end
        if (!adc_cnv[0] && pcnv) begin
            chk(cyc - rise_t == int'(cfg_width), "R2 strobe width", cyc - rise_t, cfg_width);
            fall_t = cyc; sclk_seen = 0;
        end
        if (adc_sclk && !psclk) begin
            npulse++;
            if (!sclk_seen) chk(cyc - fall_t == int'(cfg_wait) + 1, "R4 first sclk delay", cyc - fall_t, cfg_wait + 1);
            sclk_seen = 1;
        end
        if (!busy) have_rise = 0;
        if (adc_cs_n[0]) bitidx = 0;
        else if (psclk && !adc_sclk) bitidx++;
        miso_drv[0] = (adc_cs_n[0] || bitidx > 15) ? 1'b1 : cur0[15 - bitidx];
        miso_drv[1] = (adc_cs_n[1] || bitidx > 15) ? 1'b1 : cur1[15 - bitidx];
        if (mem_we) begin
            if (!wsel) begin
                chk(npulse == 16, "R4 sixteen sclk pulses", npulse, 16);
                chk(int'(mem_addr) == widx, "R5 ch0 address", mem_addr, widx);
                chk(q0.size() > 0 && mem_wdata == q0[0], "R5 ch0 data", mem_wdata, (q0.size() > 0) ? q0[0] : 0);
                if (q0.size() > 0) q0.delete(0);
            end else begin
                chk(int'(mem_addr) == ((int'(cfg_split) + widx) % 8192), "R5 ch1 address", mem_addr, int'(cfg_split) + widx);
                chk(q1.size() > 0 && mem_wdata == q1[0], "R5 ch1 data", mem_wdata, (q1.size() > 0) ? q1[0] : 0);
                if (q1.size() > 0) q1.delete(0);
                widx++;
            end
            wsel = ~wsel;
        end
        pcnv = adc_cnv[0]; psclk = adc_sclk; pbusy = busy;
    end

    task automatic setup(input int md, input int per, input int w, input int wt,
                         input int cnt, input int spl, input int ivl);
        @(negedge clk);
        cfg_mode = 2'(md); cfg_period = 16'(per); cfg_width = 16'(w); cfg_wait = 16'(wt);
        cfg_count = 14'(cnt); cfg_split = 13'(spl); cfg_interval = 24'(ivl);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic run_single(input int exp_n, input string req);
        int nb0 = n_bursts;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        wait_idle();
        chk(n_bursts - nb0 == 1, req, n_bursts - nb0, 1);
        chk(int'(samples) == exp_n, req, samples, exp_n);
        chk(widx == exp_n && !wsel, req, widx, exp_n);
        chk(done && !busy, "R12 done after burst", done, 1);
    endtask

    function automatic int min_exp(input int cnt, input int spl);
        int capv = (spl < 8192 - spl) ? spl : 8192 - spl;
        return (cnt < capv) ? cnt : capv;
    endfunction

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int t0, nb0, tk;
        void'($urandom(32'h1d2c));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk(!busy && !done && !mem_we && !adc_sclk, "R12 reset outputs", {busy, done, mem_we, adc_sclk}, 0);
        chk(adc_cnv == 2'b00 && adc_cs_n == 2'b11, "R12 reset pins", {adc_cnv, adc_cs_n}, 3);

        // R8 single burst, R2 long period
        setup(1, 60, 3, 2, 4, 100, 0);
        run_single(4, "R8 single burst");
        // R2 period shorter than the readout, no wait
        setup(1, 10, 2, 0, 3, 100, 0);
        run_single(3, "R2 short period burst");
        // R6 segment full before count (channel 1 capacity 2)
        setup(1, 45, 1, 1, 5, 8190, 0);
        run_single(2, "R6 segment full");
        // R6 channel 0 segment capacity 3
        setup(1, 45, 2, 3, 9, 3, 0);
        run_single(3, "R6 low segment full");

        // R9 continuous ignores count, stops after start drops
        setup(2, 50, 3, 2, 1, 4000, 0);
        @(negedge clk) start = 1;
        repeat (300) @(negedge clk);
        start = 0;
        wait_idle();
        chk(int'(samples) >= 5 && int'(samples) <= 7, "R9 continuous length", samples, 6);
        chk(widx == int'(samples) && !wsel, "R9 whole samples written", widx, samples);

        // R7 interval mode: launches every cfg_interval clocks
        setup(0, 50, 3, 2, 2, 100, 400);
        brise.delete();
        @(negedge clk) start = 1;
        repeat (1300) @(negedge clk);
        start = 0;
        wait_idle();
        chk(brise.size() == 4, "R7 interval burst count", brise.size(), 4);
        for (int i = 1; i < brise.size(); i++)
            chk(brise[i] - brise[i-1] == 400, "R7 interval spacing", brise[i] - brise[i-1], 400);

        // R11 undrained data drops one interval launch
        brise.delete();
        @(negedge clk) start = 1;
        repeat (200) @(negedge clk);
        drained = 0;
        repeat (300) @(negedge clk);
        chk(done && !busy, "R11 skip keeps done", {done, busy}, 2);
        repeat (100) @(negedge clk);
        drained = 1;
        repeat (300) @(negedge clk);
        start = 0;
        wait_idle();
        chk(brise.size() == 2, "R11 skipped burst count", brise.size(), 2);
        if (brise.size() == 2) chk(brise[1] - brise[0] == 800, "R11 skipped spacing", brise[1] - brise[0], 800);

        // R11 single launch with undrained data
        setup(1, 50, 3, 2, 2, 100, 0);
        drained = 0; nb0 = n_bursts;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        repeat (100) @(negedge clk);
        chk(n_bursts == nb0 && done, "R11 single dropped", n_bursts - nb0, 0);
        drained = 1;

        // R10 trigger mode with latency and ignored edges
        setup(3, 50, 3, 2, 3, 100, 0);
        @(negedge clk) start = 1;
        repeat (20) @(negedge clk);
        chk(!busy, "R10 start alone launches nothing", busy, 0);
        brise.delete(); nb0 = n_bursts;
        trig = 1; tk = cyc;
        repeat (2) @(negedge clk);
        trig = 0;
        repeat (40) @(negedge clk);
        trig = 1;
        repeat (2) @(negedge clk);
        trig = 0;
        wait_idle();
        chk(n_bursts - nb0 == 1 && int'(samples) == 3, "R10 edge in burst ignored", n_bursts - nb0, 1);
        if (brise.size() > 0) chk(brise[0] - tk == 3, "R10 trigger latency", brise[0] - tk, 3);
        repeat (10) @(negedge clk);
        trig = 1;
        repeat (3) @(negedge clk);
        trig = 0;
        repeat (5) @(negedge clk);
        wait_idle();
        chk(n_bursts - nb0 == 2, "R10 second trigger", n_bursts - nb0, 2);
        start = 0;

        // Random single bursts: R2 R4 R5 R6 over varied timing
        for (int k = 0; k < 8; k++) begin
            int per = int'($urandom_range(0, 80));
            int w = int'($urandom_range(1, 6));
            int wt = int'($urandom_range(0, 5));
            int cnt = int'($urandom_range(1, 5));
            int spl = (k % 2 == 0) ? int'($urandom_range(1, 8191)) : int'($urandom_range(1, 4));
            setup(1, per, w, wt, cnt, spl, 0);
            run_single(min_exp(cnt, spl), "R6 random burst length");
        end
        t0 = cyc;
        chk(t0 > 0, "R12 run complete", t0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule